// File: doc/BRIEF.md
# Data-Processing ALU with Status Flags

This block is the execute-stage arithmetic and logic unit of a 32-bit integer datapath. Each cycle it receives a 4-bit operation code, a first operand A and a second operand B that has already passed through the barrel shifter. It also receives the carry bit currently held by the core, a request to update the status flags, and the carry bit produced by the shifter. It returns the 32-bit result and a write-enable for the destination register. Result and write-enable are combinational.

The status flags are negative (N), zero (Z), carry (C) and overflow (V). They live in a register inside the block, which updates on the rising clock edge. The flags change only when the current operation asks for it. Compare and test operations always update them and never write a result. Additions and subtractions take C and V from the adder. Logical and move operations take C from the shifter and leave V untouched.

Top module: `dp_alu`

## Requirements
- R1: Opcode 4 (add) gives A+B and opcode 5 (add with carry) gives A+B+carry_in, both modulo 2^32, with result_we=1.
- R2: Opcode 2 (subtract) gives A-B and opcode 6 (subtract with carry) gives A-B+carry_in-1, both modulo 2^32, with result_we=1.
- R3: Opcode 3 (reverse subtract) gives B-A and opcode 7 (reverse subtract with carry) gives B-A+carry_in-1, both modulo 2^32, with result_we=1.
- R4: Opcode 0 gives A AND B, opcode 1 gives A XOR B, opcode 12 gives A OR B and opcode 14 gives A AND NOT B, each with result_we=1.
- R5: Opcode 13 gives B and opcode 15 gives bitwise NOT B, each with result_we=1.
- R6: Opcodes 8 (test, A AND B), 9 (test-equivalence, A XOR B), 10 (compare, A-B) and 11 (compare-negative, A+B) hold result_we at 0.
- R7: When the flags update, N after the clock edge equals bit 31 of the computed value and Z is 1 exactly when all 32 bits of that value are 0.
- R8: When an arithmetic or compare operation (opcodes 2-7, 10, 11) updates the flags, C becomes the adder carry-out. For subtracting forms this is the inverted borrow, so C=1 when the unsigned minuend is not smaller than the subtrahend plus any borrow.
- R9: When an arithmetic or compare operation updates the flags, V becomes 1 exactly when the two's-complement result does not fit in 32 bits.
- R10: When a logical, move or test operation (opcodes 0, 1, 8, 9, 12-15) updates the flags, C becomes shift_carry and V keeps its previous value.
- R11: With set_flags=0, the non-compare opcodes (0-7, 12-15) leave all four flags unchanged.
- R12: Opcodes 8-11 update the flags even when set_flags=0.
- R13: While rst_n is low the flags are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| opcode | input | 4 | Operation select |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand, already shifted |
| carry_in | input | 1 | Current carry flag for the carry-using forms |
| set_flags | input | 1 | Request to update the flags |
| shift_carry | input | 1 | Carry-out from the shifter |
| result | output | 32 | Computed value |
| result_we | output | 1 | Destination write-enable |
| flag_n | output | 1 | Registered negative flag |
| flag_z | output | 1 | Registered zero flag |
| flag_c | output | 1 | Registered carry flag |
| flag_v | output | 1 | Registered overflow flag |

## Verification
Two functions can occur in the same cycle: a register write and a flag update. A flag-setting arithmetic or logical operation does both at once. A compare or test does only the second, and it does so with set_flags low. The bench runs these cases back to back and feeds the same operands with set_flags both high and low. In every cycle a behavioural model computes the expected result and write-enable, and the registered flags are checked on the next cycle. This shows whether each path fired alone, together or not at all. V is first driven to 1 by an overflowing add and then followed by a flag-setting logical operation, which proves that V is held while C is replaced.

// File: rtl/alu_pkg.sv
package alu_pkg;

    localparam int OPC_W = 4;

    typedef enum logic [OPC_W-1:0] {
        OPC_AND     = 4'd0,
        OPC_XOR     = 4'd1,
        OPC_SUB     = 4'd2,
        OPC_RSUB    = 4'd3,
        OPC_ADD     = 4'd4,
        OPC_ADDC    = 4'd5,
        OPC_SUBC    = 4'd6,
        OPC_RSUBC   = 4'd7,
        OPC_TEST    = 4'd8,
        OPC_TESTEQ  = 4'd9,
        OPC_CMP     = 4'd10,
        OPC_CMPNEG  = 4'd11,
        OPC_OR      = 4'd12,
        OPC_MOVE    = 4'd13,
        OPC_CLRBITS = 4'd14,
        OPC_MOVENOT = 4'd15
    } opcode_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } flags_t;

    typedef struct packed {
        logic is_arith;
        logic is_cmp;
        logic inv_a;
        logic inv_b;
        logic swap;
        logic cin_sel;
        logic cin_const;
    } dec_t;

endpackage

// File: rtl/alu_decode.sv
module alu_decode
    import alu_pkg::*;
(
    input  opcode_e op,
    output dec_t    dec
);
    always_comb begin
        dec = '0;
        unique case (op)
            OPC_ADD, OPC_CMPNEG: begin
                dec.is_arith  = 1'b1;
                dec.cin_const = 1'b0;
            end
            OPC_ADDC: begin
                dec.is_arith = 1'b1;
                dec.cin_sel  = 1'b1;
            end
            OPC_SUB, OPC_CMP: begin
                dec.is_arith  = 1'b1;
                dec.inv_b     = 1'b1;
                dec.cin_const = 1'b1;
            end
            OPC_SUBC: begin
                dec.is_arith = 1'b1;
                dec.inv_b    = 1'b1;
                dec.cin_sel  = 1'b1;
            end
            OPC_RSUB: begin
                dec.is_arith  = 1'b1;
                dec.swap      = 1'b1;
                dec.inv_a     = 1'b1;
                dec.cin_const = 1'b1;
            end
            OPC_RSUBC: begin
                dec.is_arith = 1'b1;
                dec.swap     = 1'b1;
                dec.inv_a    = 1'b1;
                dec.cin_sel  = 1'b1;
            end
            default: dec.is_arith = 1'b0;
        endcase
        dec.is_cmp = (op == OPC_TEST) || (op == OPC_TESTEQ) ||
                     (op == OPC_CMP)  || (op == OPC_CMPNEG);
    end
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         ovf
);
    localparam int MSB = W - 1;

    logic [W:0] wide;

    always_comb begin
        wide = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
        sum  = wide[W-1:0];
        cout = wide[W];
        ovf  = (x[MSB] == y[MSB]) && (wide[MSB] != x[MSB]);
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  opcode_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res
);
    always_comb begin
        unique case (op)
            OPC_AND, OPC_TEST:   res = a & b;
            OPC_XOR, OPC_TESTEQ: res = a ^ b;
            OPC_OR:              res = a | b;
            OPC_MOVE:            res = b;
            OPC_CLRBITS:         res = a & ~b;
            OPC_MOVENOT:         res = ~b;
            default:             res = '0;
        endcase
    end
endmodule

// File: rtl/dp_alu.sv
module dp_alu
    import alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [OPC_W-1:0]     opcode,
    input  logic [W-1:0]         op_a,
    input  logic [W-1:0]         op_b,
    input  logic                 carry_in,
    input  logic                 set_flags,
    input  logic                 shift_carry,
    output logic [W-1:0]         result,
    output logic                 result_we,
    output logic                 flag_n,
    output logic                 flag_z,
    output logic                 flag_c,
    output logic                 flag_v
);
    localparam int MSB = W - 1;

    opcode_e      op;
    dec_t         dec;
    logic [W-1:0] add_x, add_y, add_sum, log_res, res_d;
    logic         add_cin, add_cout, add_ovf, upd_d;
    flags_t       flags_d, flags_q;

    assign op = opcode_e'(opcode);

    alu_decode u_dec (
        .op  (op),
        .dec (dec)
    );

    alu_adder #(.W(W)) u_add (
        .x    (add_x),
        .y    (add_y),
        .cin  (add_cin),
        .sum  (add_sum),
        .cout (add_cout),
        .ovf  (add_ovf)
    );

    alu_logic #(.W(W)) u_log (
        .op  (op),
        .a   (op_a),
        .b   (op_b),
        .res (log_res)
    );

    always_comb begin
        add_x   = dec.swap  ? op_b : op_a;
        add_y   = dec.swap  ? op_a : op_b;
        add_y   = (dec.inv_a || dec.inv_b) ? ~add_y : add_y;
        add_cin = dec.cin_sel ? carry_in : dec.cin_const;

        res_d   = dec.is_arith ? add_sum : log_res;
        upd_d   = set_flags || dec.is_cmp;

        flags_d = flags_q;
        if (upd_d) begin
            flags_d.n = res_d[MSB];
            flags_d.z = (res_d == '0);
            flags_d.c = dec.is_arith ? add_cout : shift_carry;
            flags_d.v = dec.is_arith ? add_ovf  : flags_q.v;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= flags_d;
    end

    assign result    = res_d;
    assign result_we = !dec.is_cmp;
    assign flag_n    = flags_q.n;
    assign flag_z    = flags_q.z;
    assign flag_c    = flags_q.c;
    assign flag_v    = flags_q.v;

    // R6: compare and test opcodes 8..11 never write a register
    p_cmp_no_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode[3:2] == 2'b10) |-> !result_we);

    // R11: without a flag request, a non-compare operation holds the flags
    p_flags_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_flags && opcode[3:2] != 2'b10) |=> $stable(flags_q));

    // R12: a compare always lands its sign into N
    p_cmp_sets_n_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (opcode[3:2] == 2'b10) |=> (flag_n == $past(result[MSB])));

    // R7: zero flag follows the value computed in the updating cycle
    p_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (set_flags || opcode[3:2] == 2'b10) |=> (flag_z == ($past(result) == '0)));

    // R10: logical and move operations leave V alone, C follows shifter
    p_logic_v_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (set_flags && !dec.is_arith) |=> ($stable(flag_v) && flag_c == $past(shift_carry)));

endmodule

// File: tb/sim_dp_alu.sv
module sim_dp_alu;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  opcode = '0;
    logic [31:0] op_a = '0, op_b = '0;
    logic        carry_in = 1'b0, set_flags = 1'b0, shift_carry = 1'b0;
    logic [31:0] result;
    logic        result_we, flag_n, flag_z, flag_c, flag_v;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic mn = 0, mz = 0, mc = 0, mv = 0;

    always #10 clk = ~clk;

    dp_alu u0 (
        .clk(clk), .rst_n(rst_n), .opcode(opcode), .op_a(op_a), .op_b(op_b),
        .carry_in(carry_in), .set_flags(set_flags), .shift_carry(shift_carry),
        .result(result), .result_we(result_we),
        .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_flags(input string req);
        chk(req, {28'd0, flag_n, flag_z, flag_c, flag_v}, {28'd0, mn, mz, mc, mv});
    endtask

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            4'd4, 4'd5:         return "R1";
            4'd2, 4'd6:         return "R2";
            4'd3, 4'd7:         return "R3";
            4'd0, 4'd1, 4'd12, 4'd14: return "R4";
            4'd13, 4'd15:       return "R5";
            default:            return "R6";
        endcase
    endfunction

    string flag_tag = "R13";

    task automatic apply(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic ci, input logic sf, input logic sc);
        longint ua, ub, u, sa, sb, s, bor;
        logic [31:0] er;
        logic arith, cmp, ew, upd;
        @(negedge clk);
        check_flags(flag_tag);
        opcode = op; op_a = a; op_b = b; carry_in = ci; set_flags = sf; shift_carry = sc;
        #5;
        ua = longint'(a); ub = longint'(b);
        sa = longint'($signed(a)); sb = longint'($signed(b));
        bor = ci ? 0 : 1;
        arith = 1; u = 0; s = 0; er = '0;
        case (op)
            4'd4, 4'd11: begin u = ua + ub;      s = sa + sb; end
            4'd5:        begin u = ua + ub + (1 - bor); s = sa + sb + (1 - bor); end
            4'd2, 4'd10: begin u = ua - ub;      s = sa - sb; end
            4'd6:        begin u = ua - ub - bor; s = sa - sb - bor; end
            4'd3:        begin u = ub - ua;      s = sb - sa; end
            4'd7:        begin u = ub - ua - bor; s = sb - sa - bor; end
            default: arith = 0;
        endcase
        if (arith) er = u[31:0];
        else case (op)
            4'd0, 4'd8: er = a & b;
            4'd1, 4'd9: er = a ^ b;
            4'd12:      er = a | b;
            4'd13:      er = b;
            4'd14:      er = a & ~b;
            default:    er = ~b;
        endcase
        cmp = (op >= 4'd8 && op <= 4'd11);
        ew  = !cmp;
        chk({tag_of(op), "/R6 we"}, {31'd0, result_we}, {31'd0, ew});
        if (ew) chk(tag_of(op), result, er);
        upd = sf || cmp;
        if (upd) begin
            mn = er[31];
            mz = (er == 32'd0);
            if (arith) begin
                if (op == 4'd4 || op == 4'd5 || op == 4'd11) mc = (u >= 64'sh1_0000_0000);
                else mc = (u >= 0);
                mv = (s > 64'sd2147483647) || (s < -64'sd2147483648);
                flag_tag = cmp ? "R12/R7/R8/R9" : "R7/R8/R9";
            end else begin
                mc = sc;
                flag_tag = cmp ? "R12/R7/R10" : "R7/R10";
            end
        end else flag_tag = "R11";
    endtask

    initial begin
        #4_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_flags("R13");
        @(negedge clk);
        rst_n = 1'b1;

        // R1 adds, overflow and carry corners
        apply(4'd4, 32'h7FFF_FFFF, 32'h0000_0001, 0, 1, 0);
        apply(4'd4, 32'hFFFF_FFFF, 32'h0000_0001, 0, 1, 0);
        apply(4'd5, 32'h0000_0010, 32'h0000_0020, 1, 1, 0);
        // R2 subtracts with borrow, carry as inverted borrow (R8)
        apply(4'd2, 32'h0000_0005, 32'h0000_0007, 0, 1, 0);
        apply(4'd2, 32'h8000_0000, 32'h0000_0001, 0, 1, 0);
        apply(4'd6, 32'h0000_0005, 32'h0000_0005, 0, 1, 0);
        apply(4'd6, 32'h0000_0005, 32'h0000_0005, 1, 1, 0);
        // R3 reverse forms
        apply(4'd3, 32'h0000_0003, 32'h0000_0010, 0, 1, 0);
        apply(4'd7, 32'h0000_0003, 32'h0000_0010, 0, 1, 0);
        // R9 overflow set, then R10 logical keeps V, takes shifter carry
        apply(4'd4, 32'h4000_0000, 32'h4000_0000, 0, 1, 0);
        apply(4'd14, 32'h53AF_DA6B, 32'hFFFF_0000, 0, 1, 1);
        apply(4'd15, 32'h0, 32'h53AF_DA6B, 0, 1, 0);
        apply(4'd13, 32'h0, 32'h0, 0, 1, 1);
        // R11 flags held without request
        apply(4'd2, 32'h0, 32'h1, 0, 0, 1);
        apply(4'd0, 32'h0, 32'h0, 0, 0, 1);
        // R12 compares with set_flags low, R6 no write
        apply(4'd10, 32'h0000_0009, 32'h0000_0009, 0, 0, 0);
        apply(4'd11, 32'h8000_0000, 32'h8000_0000, 0, 0, 0);
        apply(4'd8, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 0, 0, 1);
        apply(4'd9, 32'h8000_0001, 32'h0000_0001, 0, 0, 0);
        apply(4'd12, 32'h1234_0000, 32'h0000_5678, 0, 1, 0);
        apply(4'd1, 32'hAAAA_AAAA, 32'hAAAA_AAAA, 0, 1, 0);

        for (int i = 0; i < 600; i++) begin
            logic [31:0] ra, rb;
            ra = $urandom;
            rb = $urandom;
            if (i % 7 == 0) rb = ra;
            if (i % 11 == 0) ra = 32'h8000_0000;
            if (i % 13 == 0) rb = 32'hFFFF_FFFF;
            apply(4'($urandom), ra, rb, 1'($urandom), 1'($urandom), 1'($urandom));
        end

        @(negedge clk);
        check_flags(flag_tag);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule